// File: doc/BRIEF.md
# Quad-word burst limiter with lane replication

This block is the slave-side front end between a 32-bit system bus and a memory that always moves data in 16-byte quad words. Each cycle it looks at one bus beat: its address, its size (byte, half-word or word), whether it continues the current burst, and whether it writes. It raises a last-beat signal on the beat that finishes a quad word, so the master must break its burst there. This applies whether the burst started aligned or part-way through a quad word.

Write beats are collected into a 16-byte enable mask and a 128-bit data image for the quad word they fall in. The quad word is released once it closes on its last beat, or when the transfer stops short. A short stop is an idle cycle or a new non-sequential beat. Bytes that no beat wrote stay masked off.

Read beats take one 32-bit word from memory and return it on the bus. A half-word is copied into both halves of the bus and a byte into all four lanes, so a master reading any lane sees the right value. Memory command sequencing lies outside this block.

Top module: `qw_burst_limiter`

## Requirements
- R1: `burst_last` is high only on a valid beat whose offset (address bits [3:0]) is the final unit of the quad word for its size: 0xF for a byte, 0xE for a half-word, 0xC for a word. It is low in idle cycles.
- R2: A burst that starts at a non-zero offset gets `burst_last` on the beat that completes that quad word. Example: a word burst from offset 0x4 breaks on its third beat.
- R3: A word burst that would run past four words gets `burst_last` on its fourth word, so it is split at the quad-word edge.
- R4: On a half-word read (`bus_size` = 2'b01), address bit 1 selects `mem_rdata[31:16]` (1) or `mem_rdata[15:0]` (0). That half-word is driven on both `bus_rdata[31:16]` and `bus_rdata[15:0]`.
- R5: On a byte read (`bus_size` = 2'b00), address bits [1:0] select byte lane n, which is `mem_rdata[8n+7:8n]`. That byte is driven on all four byte lanes of `bus_rdata`.
- R6: On a word read (`bus_size` = 2'b10), `bus_rdata` equals `mem_rdata`. The code 2'b11 is treated exactly as a word for both read data and `burst_last`.
- R7: A write beat enables the bytes of its own unit within the quad word: 1, 2 or 4 bytes starting at the offset rounded down to the size. The data of quad byte b is taken from bus lane b mod 4 of `bus_wdata`. A released mask is never empty.
- R8: A write beat with `burst_last` closes its quad word. `qw_valid` is high for one cycle, two clock edges after that beat. `qw_base` is then address bits [ADDR_W-1:4], and `qw_mask`/`qw_data` hold every byte written in that quad word.
- R9: An open, partly written quad word is released with `qw_valid` one clock edge after an idle cycle or a non-sequential beat. Unwritten bytes are 0 in `qw_mask`. A non-sequential write that arrives at that moment starts a new quad word.
- R10: Reset clears `qw_valid` and discards any partly collected quad word, so it is never released.
- R11: Read beats never change the collected write state and never cause `qw_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A beat is present this cycle |
| bus_seq | input | 1 | Beat continues the current burst (0 = first beat of a transfer) |
| bus_write | input | 1 | Beat is a write |
| bus_size | input | 2 | 00 byte, 01 half-word, 10 or 11 word |
| bus_addr | input | ADDR_W | Byte address of the beat |
| bus_wdata | input | 32 | Write data, lane-positioned |
| mem_rdata | input | 32 | Word read from memory for this beat |
| burst_last | output | 1 | Master must end its burst after this beat |
| bus_rdata | output | 32 | Read data with narrow values replicated |
| qw_valid | output | 1 | A closed quad word is presented this cycle |
| qw_base | output | ADDR_W-4 | Quad-word address of the released data |
| qw_mask | output | 16 | Per-byte write enables of the released quad word |
| qw_data | output | 128 | Write data of the released quad word |

## Verification
The bench aims at boundary offsets where sizes disagree. A half-word at 0xC and a word at 0x8 must not break. A detector that compared only against 0xF would miss every wider size. Misaligned and longer-than-four word bursts check that the break comes from the offset and not from a beat count; a counter-based design would break a burst from 0x4 one beat late. Release timing is checked in three ways: closing on the last beat, flushing on an idle cycle, and flushing on a non-sequential write that itself closes a quad word. A design that merged those two quad words, or dropped either one, shows a wrong mask or base. Lane selection on reads is checked per lane, and a reset in the middle of a write must not leak a stale release.

// File: rtl/qwl_pkg.sv
package qwl_pkg;

  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int QW_BYTES   = 16;
  localparam int QW_W       = 8 * QW_BYTES;
  localparam int OFF_W      = $clog2(QW_BYTES);
  localparam int LANE_W     = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } qwl_size_e;

  // Offset bits that lie inside one unit of the given size.
  function automatic logic [OFF_W-1:0] size_low_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_low_mask = OFF_W'(0);
      SZ_HALF: size_low_mask = OFF_W'(1);
      default: size_low_mask = OFF_W'(WORD_BYTES - 1);
    endcase
  endfunction

  // A beat closes its quad word when its unit reaches the top of it.
  function automatic logic beat_closes_qw(input logic [OFF_W-1:0] off, input logic [1:0] sz);
    beat_closes_qw = &(off | size_low_mask(sz));
  endfunction

  // Bytes of the quad word covered by one beat.
  function automatic logic [QW_BYTES-1:0] beat_byte_mask(input logic [OFF_W-1:0] off,
                                                         input logic [1:0] sz);
    logic [OFF_W-1:0] lm;
    lm = size_low_mask(sz);
    for (int i = 0; i < QW_BYTES; i++)
      beat_byte_mask[i] = ((OFF_W'(i) | lm) == (off | lm));
  endfunction

endpackage

// File: rtl/qwl_break.sv
module qwl_break
  import qwl_pkg::*;
(
  input  logic             valid_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic             last_o
);

  always_comb last_o = valid_i && beat_closes_qw(off_i, size_i);

endmodule

// File: rtl/qwl_mirror.sv
module qwl_mirror
  import qwl_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [WORD_W-1:0] mem_i,
  output logic [WORD_W-1:0] bus_o
);

  logic [7:0]  sel_byte;
  logic [15:0] sel_half;

  always_comb begin
    sel_byte = mem_i[8*lane_i +: 8];
    sel_half = lane_i[LANE_W-1] ? mem_i[WORD_W-1 -: 16] : mem_i[15:0];
    case (size_i)
      SZ_BYTE: bus_o = {WORD_BYTES{sel_byte}};
      SZ_HALF: bus_o = {(WORD_BYTES/2){sel_half}};
      default: bus_o = mem_i;
    endcase
  end

endmodule

// File: rtl/qwl_merge.sv
module qwl_merge
  import qwl_pkg::*;
#(
  parameter int BASE_W = 28
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              seq_i,
  input  logic              write_i,
  input  logic              last_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              qw_valid_o,
  output logic [BASE_W-1:0] qw_base_o,
  output logic [QW_BYTES-1:0] qw_mask_o,
  output logic [QW_W-1:0]   qw_data_o
);

  logic [QW_BYTES-1:0] acc_mask, acc_mask_n;
  logic [QW_W-1:0]     acc_data, acc_data_n;
  logic [BASE_W-1:0]   acc_base, acc_base_n;
  logic                acc_closed, acc_closed_n;

  // Named events for the assertions.
  logic                acc_any;
  logic                wr_beat;
  logic                release_now;
  logic [QW_BYTES-1:0] beat_m;

  always_comb begin
    acc_any     = |acc_mask;
    wr_beat     = valid_i && write_i;
    release_now = acc_any && (acc_closed || !valid_i || !seq_i);
    beat_m      = wr_beat ? beat_byte_mask(off_i, size_i) : '0;
  end

  always_comb begin
    acc_mask_n   = acc_mask;
    acc_data_n   = acc_data;
    acc_base_n   = acc_base;
    acc_closed_n = acc_closed;
    if (release_now) begin
      acc_mask_n   = '0;
      acc_data_n   = '0;
      acc_closed_n = 1'b0;
    end
    if (wr_beat) begin
      for (int i = 0; i < QW_BYTES; i++)
        if (beat_m[i]) acc_data_n[8*i +: 8] = wdata_i[8*(i % WORD_BYTES) +: 8];
      acc_mask_n   = acc_mask_n | beat_m;
      acc_base_n   = base_i;
      acc_closed_n = last_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_mask   <= '0;
      acc_data   <= '0;
      acc_base   <= '0;
      acc_closed <= 1'b0;
      qw_valid_o <= 1'b0;
      qw_base_o  <= '0;
      qw_mask_o  <= '0;
      qw_data_o  <= '0;
    end else begin
      acc_mask   <= acc_mask_n;
      acc_data   <= acc_data_n;
      acc_base   <= acc_base_n;
      acc_closed <= acc_closed_n;
      qw_valid_o <= release_now;
      if (release_now) begin
        qw_base_o <= acc_base;
        qw_mask_o <= acc_mask;
        qw_data_o <= acc_data;
      end
    end
  end

  AST_CLOSE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_beat && last_i) |=> release_now);                              // R8
  AST_IDLE_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_any && !valid_i) |=> qw_valid_o);                             // R9
  AST_MASK_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    qw_valid_o |-> (qw_mask_o != '0));                                 // R7
  AST_READ_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_any && !wr_beat) |=> !acc_any);                              // R11

endmodule

// File: rtl/qw_burst_limiter.sv
module qw_burst_limiter
  import qwl_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_seq,
  input  logic                bus_write,
  input  logic [1:0]          bus_size,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                burst_last,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                qw_valid,
  output logic [ADDR_W-OFF_W-1:0] qw_base,
  output logic [QW_BYTES-1:0] qw_mask,
  output logic [QW_W-1:0]     qw_data
);

  localparam int BASE_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0]  beat_off;
  logic [BASE_W-1:0] beat_base;

  always_comb begin
    beat_off  = bus_addr[OFF_W-1:0];
    beat_base = bus_addr[ADDR_W-1:OFF_W];
  end

  qwl_break u_break (
    .valid_i (bus_valid),
    .off_i   (beat_off),
    .size_i  (bus_size),
    .last_o  (burst_last)
  );

  qwl_mirror u_mirror (
    .size_i (bus_size),
    .lane_i (beat_off[LANE_W-1:0]),
    .mem_i  (mem_rdata),
    .bus_o  (bus_rdata)
  );

  qwl_merge #(.BASE_W(BASE_W)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (bus_valid),
    .seq_i      (bus_seq),
    .write_i    (bus_write),
    .last_i     (burst_last),
    .base_i     (beat_base),
    .off_i      (beat_off),
    .size_i     (bus_size),
    .wdata_i    (bus_wdata),
    .qw_valid_o (qw_valid),
    .qw_base_o  (qw_base),
    .qw_mask_o  (qw_mask),
    .qw_data_o  (qw_data)
  );

  AST_IDLE_NO_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> !burst_last);                                       // R1
  AST_HALF_MIRRORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_size == SZ_HALF)
      |-> (bus_rdata[31:16] == bus_rdata[15:0]));                      // R4
  AST_BYTE_MIRRORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_size == SZ_BYTE)
      |-> (bus_rdata == {4{bus_rdata[7:0]}}));                         // R5

endmodule

// File: tb/sim_qw_burst_limiter.sv
module sim_qw_burst_limiter;

  localparam int ADDR_W = 32;
  localparam int BASE_W = ADDR_W - 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_valid, bus_seq, bus_write;
  logic [1:0]        bus_size;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, mem_rdata;
  logic              burst_last;
  logic [31:0]       bus_rdata;
  logic              qw_valid;
  logic [BASE_W-1:0] qw_base;
  logic [15:0]       qw_mask;
  logic [127:0]      qw_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  qw_burst_limiter #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_seq(bus_seq),
    .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mem_rdata(mem_rdata), .burst_last(burst_last),
    .bus_rdata(bus_rdata), .qw_valid(qw_valid), .qw_base(qw_base),
    .qw_mask(qw_mask), .qw_data(qw_data)
  );

  // Read vectors: size, offset, memory word, expected break, expected bus data.
  typedef struct packed {
    logic [1:0]  sz;
    logic [3:0]  off;
    logic [31:0] mem;
    logic        last;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'h5, 32'hAABBCCDD, 1'b0, 32'hCCCCCCCC},  // R5 lane 1
    '{2'd0, 4'hF, 32'hAABBCCDD, 1'b1, 32'hAAAAAAAA},  // R1 R5 lane 3
    '{2'd0, 4'h0, 32'hAABBCCDD, 1'b0, 32'hDDDDDDDD},  // R5 lane 0
    '{2'd1, 4'hE, 32'hAABBCCDD, 1'b1, 32'hAABBAABB},  // R1 R4 upper
    '{2'd1, 4'h4, 32'hAABBCCDD, 1'b0, 32'hCCDDCCDD},  // R4 lower
    '{2'd1, 4'hC, 32'hAABBCCDD, 1'b0, 32'hCCDDCCDD},  // R1 half not at 0xC
    '{2'd2, 4'hC, 32'hAABBCCDD, 1'b1, 32'hAABBCCDD},  // R3 R6
    '{2'd2, 4'h8, 32'hAABBCCDD, 1'b0, 32'hAABBCCDD},  // R1 R6
    '{2'd3, 4'hC, 32'h11223344, 1'b1, 32'h11223344},  // R6 code 11
    '{2'd3, 4'h4, 32'h11223344, 1'b0, 32'h11223344},  // R6 code 11
    '{2'd1, 4'h2, 32'h12345678, 1'b0, 32'h12341234},  // R4
    '{2'd0, 4'hE, 32'h12345678, 1'b0, 32'h34343434},  // R5 lane 2
    '{2'd0, 4'h3, 32'h12345678, 1'b0, 32'h12121212}   // R5 lane 3
  };

  logic [15:0]  m_mask;
  logic [127:0] m_data;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_mask = '0;
    m_data = '0;
  endtask

  task automatic model_add(input logic [31:0] addr, input logic [1:0] sz, input logic [31:0] wd);
    int n;
    int start;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    start = int'(addr[3:0]) - (int'(addr[3:0]) % n);
    for (int j = 0; j < n; j++) begin
      m_mask[start + j] = 1'b1;
      m_data[8*(start + j) +: 8] = wd[8*((start + j) % 4) +: 8];
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic w, input logic [1:0] sz,
                       input logic [31:0] addr, input logic [31:0] wd, input logic [31:0] md);
    bus_valid = v; bus_seq = s; bus_write = w; bus_size = sz;
    bus_addr = addr; bus_wdata = wd; mem_rdata = md;
  endtask

  task automatic beat(input logic s, input logic w, input logic [1:0] sz, input logic [31:0] addr,
                      input logic [31:0] wd, input logic exp_last, input string req);
    drive(1'b1, s, w, sz, addr, wd, 32'h0);
    #1;
    chk(req, {127'd0, burst_last}, {127'd0, exp_last});
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0);
    @(negedge clk);
  endtask

  task automatic chk_release(input string req, input logic [BASE_W-1:0] base);
    chk(req, {127'd0, qw_valid}, 128'd1);
    chk(req, {{(128-BASE_W){1'b0}}, qw_base}, {{(128-BASE_W){1'b0}}, base});
    chk(req, {112'd0, qw_mask}, {112'd0, m_mask});
    chk(req, qw_data, m_data);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0]       s_mask;
    logic [127:0]      s_data;
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset qw_valid", {127'd0, qw_valid}, 128'd0);
    chk("R1 idle no break", {127'd0, burst_last}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: read beats
    for (int k = 0; k < NV; k++) begin
      drive(1'b1, 1'b0, 1'b0, VEC[k].sz, {28'h0000123, VEC[k].off}, 32'h0, VEC[k].mem);
      #1;
      chk("R1 R3 R6 break on read vector", {127'd0, burst_last}, {127'd0, VEC[k].last});
      chk("R4 R5 R6 read data vector", {96'd0, bus_rdata}, {96'd0, VEC[k].rd});
      @(negedge clk);
      chk("R11 reads release nothing", {127'd0, qw_valid}, 128'd0);
    end
    idle();
    chk("R11 reads release nothing after idle", {127'd0, qw_valid}, 128'd0);

    // Aligned word burst of four: closes on 0x10C
    model_clear();
    for (int k = 0; k < 4; k++) begin
      model_add(32'h100 + 4*k, 2'd2, 32'hA0B0C000 + k);
      beat(k != 0, 1'b1, 2'd2, 32'h100 + 4*k, 32'hA0B0C000 + k, k == 3, "R3 aligned word burst break");
    end
    chk("R8 not yet released", {127'd0, qw_valid}, 128'd0);
    idle();
    chk_release("R8 close on last beat", 28'h0000010);
    idle();
    chk("R8 single-cycle release", {127'd0, qw_valid}, 128'd0);

    // Word burst longer than four: break at 0x20C, continue non-sequentially
    model_clear();
    for (int k = 0; k < 4; k++) begin
      model_add(32'h200 + 4*k, 2'd2, 32'h5A000000 + k);
      beat(k != 0, 1'b1, 2'd2, 32'h200 + 4*k, 32'h5A000000 + k, k == 3, "R3 break at fourth word");
    end
    s_mask = m_mask; s_data = m_data;
    model_clear();
    model_add(32'h210, 2'd2, 32'h66666666);
    beat(1'b0, 1'b1, 2'd2, 32'h210, 32'h66666666, 1'b0, "R3 next quad first word");
    chk("R8 release during next write", {127'd0, qw_valid}, 128'd1);
    chk("R8 mask of first quad", {112'd0, qw_mask}, {112'd0, s_mask});
    chk("R8 data of first quad", qw_data, s_data);
    model_add(32'h214, 2'd2, 32'h77777777);
    beat(1'b1, 1'b1, 2'd2, 32'h214, 32'h77777777, 1'b0, "R3 second word");
    idle();
    chk_release("R9 short tail flushed by idle", 28'h0000021);

    // Misaligned half-word burst from 0x30A: break at 0x30E
    model_clear();
    for (int k = 0; k < 3; k++) begin
      model_add(32'h30A + 2*k, 2'd1, 32'hB1B2C3C4 + 32'h01010101 * k);
      beat(k != 0, 1'b1, 2'd1, 32'h30A + 2*k, 32'hB1B2C3C4 + 32'h01010101 * k, k == 2,
           "R2 misaligned half break");
    end
    idle();
    chk_release("R2 R7 misaligned half release", 28'h0000030);
    chk("R7 half mask value", {112'd0, qw_mask}, {112'd0, 16'hFC00});

    // Misaligned word burst from 0x404: break on third beat
    model_clear();
    for (int k = 0; k < 3; k++) begin
      model_add(32'h404 + 4*k, 2'd2, 32'h0F0E0D0C + k);
      beat(k != 0, 1'b1, 2'd2, 32'h404 + 4*k, 32'h0F0E0D0C + k, k == 2, "R2 misaligned word break");
    end
    idle();
    chk_release("R2 misaligned word release", 28'h0000040);

    // Single byte write, flushed by idle
    model_clear();
    model_add(32'h205, 2'd0, 32'h00EE0000 | 32'h0000C300);
    beat(1'b0, 1'b1, 2'd0, 32'h205, 32'h00EEC300, 1'b0, "R1 byte at 0x5 no break");
    idle();
    chk_release("R9 R7 single byte", 28'h0000020);
    chk("R7 byte mask value", {112'd0, qw_mask}, {112'd0, 16'h0020});

    // Flush by a non-sequential write that itself closes a quad word
    model_clear();
    model_add(32'h500, 2'd2, 32'hCAFE0001);
    beat(1'b0, 1'b1, 2'd2, 32'h500, 32'hCAFE0001, 1'b0, "R1 word at 0x0 no break");
    s_mask = m_mask; s_data = m_data;
    model_clear();
    model_add(32'h60C, 2'd2, 32'hBEEF0002);
    beat(1'b0, 1'b1, 2'd2, 32'h60C, 32'hBEEF0002, 1'b1, "R1 word at 0xC break");
    chk("R9 old quad released on nonseq", {127'd0, qw_valid}, 128'd1);
    chk("R9 old quad base", {100'd0, qw_base}, {100'd0, 28'h0000050});
    chk("R9 old quad mask", {112'd0, qw_mask}, {112'd0, s_mask});
    chk("R9 old quad data", qw_data, s_data);
    idle();
    chk_release("R8 new quad released next", 28'h0000060);

    // Reset in the middle of a write: nothing leaks
    beat(1'b0, 1'b1, 2'd0, 32'h702, 32'h00110000, 1'b0, "R1 byte at 0x2 no break");
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 no stale release", {127'd0, qw_valid}, 128'd0);
    @(negedge clk);
    chk("R10 no stale release later", {127'd0, qw_valid}, 128'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule